// File: doc/BRIEF.md
# Reciprocal Square-Root Seed Unit

This unit produces a first guess of 1/sqrt(x) for a binary floating-point operand. The guess has about seven good bits. An iterative refinement step, such as a Newton–Raphson stage or a vector estimate instruction, can use it directly. The operand format comes from two parameters: the exponent width and the fraction width. Half (5/10), single (8/23) and double (11/52) layouts are all supported. Special operands skip the table and return fixed results with the matching flag. Positive subnormals are normalised before the lookup, so they yield full-accuracy seeds.

Operands arrive on a valid/ready stream. Each result leaves on a second valid/ready stream one cycle after it is accepted.

The unit has one output register. While that register is empty, or while the consumer is taking its contents in the current cycle, the unit accepts a new operand. While the consumer holds `out_ready` low, a waiting result stays frozen, `in_ready` stays low, and offered operands wait on the input.

Top module: `rsq_est`

## Requirements
- R1: An operand is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. `in_ready` is high exactly when the output register is empty or `out_ready` is high, and `out_valid` clears after a taken result if no new operand is taken.
- R2: While `out_valid` is high and `out_ready` is low, `out_data`, `out_invalid` and `out_divzero` hold their values and no new operand is taken.
- R3: The following operands give the canonical NaN with `out_invalid` = 1 and `out_divzero` = 0. These are negative infinity, any negative nonzero finite value, and any signalling NaN (all-ones exponent, nonzero fraction, fraction MSB 0). The canonical NaN is sign 0, all-ones exponent, fraction MSB 1 and all other fraction bits 0; for the default format it is 0x7FC00000.
- R4: A quiet NaN (fraction MSB 1) of either sign gives the canonical NaN with both flags 0.
- R5: +0 gives +infinity and -0 gives -infinity. In both cases `out_divzero` = 1 and `out_invalid` = 0.
- R6: +infinity gives +0 with both flags 0.
- R7: A positive normal operand with biased exponent e and fraction f gives a result with sign 0 and no flags. The result exponent is floor((3B - 1 - e)/2), where B = 2^(E-1) - 1.
- R8: For a positive normal or subnormal operand, the 7-bit seed forms the top 7 fraction bits of the result, and the remaining fraction bits are 0. The seed is addressed by {LSB of the normalised exponent, top 6 bits of the normalised fraction}. With m = 1 + (2i+1)/128 for index i, the seed is round(128*v) - 128. Here v = 2/sqrt(m) when the parity bit is 1 and v = sqrt(2)/sqrt(m) when it is 0.
- R9: A positive subnormal operand whose fraction has z leading zeros is treated as having exponent -z. Its fraction is shifted left by z+1 and kept to the fraction width before the lookup and the R7 exponent formula are applied. For example, 0x00000001 gives 0x64B40000.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R11: `out_invalid` and `out_divzero` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand on `in_data` is offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_data | input | 1+EXP_W+FRAC_W | Floating-point operand |
| out_valid | output | 1 | Result on the output is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 1+EXP_W+FRAC_W | Reciprocal square-root estimate |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_divzero | output | 1 | Divide-by-zero flag for this result |

## Verification
The hardest cases to reach are subnormal operands with many leading zeros, whose normalised exponent is negative. In two's complement the parity of a negative exponent selects the table half, so a sign-handling slip picks the wrong half only for an odd leading-zero count. Uniform random operands almost never land there. The stimulus therefore builds subnormals by shifting a random fraction right by a random amount from 0 to 22, which spreads the leading-zero count over its whole range. Directed operands at both ends of that range check the exponent formula exactly. A separate sequence holds the consumer off for several cycles while a second operand waits, then releases it, to show that the frozen result and the hand-over behave as required.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // lookup geometry: one parity bit plus six fraction bits, seven-bit seeds
  localparam int unsigned RSQ_IDX_W   = 6;
  localparam int unsigned RSQ_OUT_W   = 7;
  localparam int unsigned RSQ_ADDR_W  = RSQ_IDX_W + 1;
  localparam int unsigned RSQ_HALF    = 1 << RSQ_IDX_W;
  localparam int unsigned RSQ_ENTRIES = 1 << RSQ_ADDR_W;

  typedef enum logic [2:0] {
    CLS_POS_NORM = 3'd0,
    CLS_POS_SUB  = 3'd1,
    CLS_ZERO     = 3'd2,
    CLS_POS_INF  = 3'd3,
    CLS_INVALID  = 3'd4,
    CLS_QUIET    = 3'd5
  } rsq_class_e;

  // integer square root, floor, for values below 2^20
  function automatic int isqrt20(input int t);
    int r;
    int c;
    r = 0;
    for (int b = 9; b >= 0; b--) begin
      c = r | (1 << b);
      if (c * c <= t) r = c;
    end
    return r;
  endfunction

  // Seed for bin idx of one half. The bin centre is m = (2*HALF + 2*idx + 1) / (2*HALF).
  // With q = 128 * v, the seed is round(q) - 128; q^2 = 2^23/d (odd half) or 2^22/d (even half).
  // round(q) = n  <=>  (2n-1)^2 * d <= 4 * q^2 * d, solved with an integer root.
  function automatic logic [RSQ_OUT_W-1:0] rsq_seed(input int odd, input int idx);
    int d;
    int t;
    int n;
    d = 2 * RSQ_HALF + 2 * idx + 1;
    t = ((odd != 0) ? (1 << 25) : (1 << 24)) / d;
    n = (isqrt20(t) + 1) / 2;
    if (n > 255) n = 255;
    if (n < 128) n = 128;
    return RSQ_OUT_W'(n - 128);
  endfunction

  function automatic logic [RSQ_ENTRIES*RSQ_OUT_W-1:0] build_rom();
    logic [RSQ_ENTRIES*RSQ_OUT_W-1:0] r;
    r = '0;
    for (int a = 0; a < RSQ_ENTRIES; a++)
      r[a*RSQ_OUT_W +: RSQ_OUT_W] = rsq_seed(a >> RSQ_IDX_W, a & (RSQ_HALF - 1));
    return r;
  endfunction

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output rsq_class_e        cls_o
);

  logic exp_ones;
  logic exp_zero;
  logic frac_zero;

  assign exp_ones  = &exp_i;
  assign exp_zero  = ~|exp_i;
  assign frac_zero = ~|frac_i;

  always_comb begin
    if (exp_ones) begin
      if (frac_zero)             cls_o = sign_i ? CLS_INVALID : CLS_POS_INF;
      else if (frac_i[FRAC_W-1]) cls_o = CLS_QUIET;
      else                       cls_o = CLS_INVALID;
    end else if (exp_zero && frac_zero) begin
      cls_o = CLS_ZERO;
    end else if (sign_i) begin
      cls_o = CLS_INVALID;
    end else if (exp_zero) begin
      cls_o = CLS_POS_SUB;
    end else begin
      cls_o = CLS_POS_NORM;
    end
  end

endmodule

// File: rtl/rsq_normalize.sv
module rsq_normalize
  import rsq_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned NE_W   = EXP_W + 3
) (
  input  logic                   is_sub_i,
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [FRAC_W-1:0]      frac_i,
  output logic signed [NE_W-1:0] norm_exp_o,
  output logic [RSQ_IDX_W-1:0]   norm_idx_o
);

  localparam int unsigned LZ_W = $clog2(FRAC_W + 2);

  logic [LZ_W-1:0] lz;
  logic [LZ_W-1:0] sh_amt;
  logic            found;

  // leading zeros of the fraction field, counted from its MSB
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!found && frac_i[i]) found = 1'b1;
      else if (!found)         lz    = lz + 1'b1;
    end
  end

  // a subnormal drops its leading zeros and its leading one; a normal is not shifted
  assign sh_amt     = is_sub_i ? (lz + 1'b1) : '0;
  assign norm_idx_o = RSQ_IDX_W'((frac_i << sh_amt) >> (FRAC_W - RSQ_IDX_W));
  assign norm_exp_o = is_sub_i ? (NE_W'(0) - NE_W'(lz)) : NE_W'(exp_i);

endmodule

// File: rtl/rsq_rom.sv
module rsq_rom
  import rsq_pkg::*;
(
  input  logic [RSQ_ADDR_W-1:0] addr_i,
  output logic [RSQ_OUT_W-1:0]  seed_o
);

  localparam logic [RSQ_ENTRIES*RSQ_OUT_W-1:0] SEEDS = build_rom();

  assign seed_o = SEEDS[int'(addr_i)*RSQ_OUT_W +: RSQ_OUT_W];

endmodule

// File: rtl/rsq_est.sv
module rsq_est
  import rsq_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [EXP_W+FRAC_W:0]     in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_W+FRAC_W:0]     out_data,
  output logic                      out_invalid,
  output logic                      out_divzero
);

  localparam int unsigned W    = 1 + EXP_W + FRAC_W;
  localparam int unsigned NE_W = EXP_W + 3;
  localparam int          BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [NE_W-1:0] EXP_NUM = NE_W'(3 * BIAS - 1);
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                   op_sign;
  logic [EXP_W-1:0]       op_exp;
  logic [FRAC_W-1:0]      op_frac;
  rsq_class_e             cls;
  logic signed [NE_W-1:0] norm_exp;
  logic [RSQ_IDX_W-1:0]   norm_idx;
  logic [RSQ_OUT_W-1:0]   seed;
  logic [EXP_W-1:0]       res_exp;
  logic [W-1:0]           res_word;
  logic                   res_inv;
  logic                   res_dz;
  logic                   take;

  assign op_sign = in_data[W-1];
  assign op_exp  = in_data[W-2 -: EXP_W];
  assign op_frac = in_data[FRAC_W-1:0];

  rsq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .sign_i (op_sign),
    .exp_i  (op_exp),
    .frac_i (op_frac),
    .cls_o  (cls)
  );

  rsq_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .NE_W(NE_W)) u_norm (
    .is_sub_i   (cls == CLS_POS_SUB),
    .exp_i      (op_exp),
    .frac_i     (op_frac),
    .norm_exp_o (norm_exp),
    .norm_idx_o (norm_idx)
  );

  rsq_rom u_rom (
    .addr_i ({norm_exp[0], norm_idx}),
    .seed_o (seed)
  );

  // floor((3B - 1 - e) / 2); the numerator is always positive
  assign res_exp = EXP_W'((EXP_NUM - norm_exp) >>> 1);

  always_comb begin
    res_inv  = 1'b0;
    res_dz   = 1'b0;
    res_word = {1'b0, res_exp, seed, {(FRAC_W-RSQ_OUT_W){1'b0}}};
    unique case (cls)
      CLS_INVALID: begin
        res_word = CANON_NAN;
        res_inv  = 1'b1;
      end
      CLS_QUIET:   res_word = CANON_NAN;
      CLS_ZERO: begin
        res_word = {op_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        res_dz   = 1'b1;
      end
      CLS_POS_INF: res_word = '0;
      default:     ;
    endcase
  end

  // single output register; it may refill in the cycle it drains
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_divzero <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_data    <= res_word;
      out_invalid <= res_inv;
      out_divzero <= res_dz;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/rsq_est_chk.sv
module rsq_est_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] out_data,
  input logic                  out_invalid,
  input logic                  out_divzero
);

  localparam int unsigned W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_invalid) && $stable(out_divzero));

  // R2
  no_take_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3
  nan_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_data == CANON_NAN);

  // R5
  inf_on_divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_divzero |-> (&out_data[W-2 -: EXP_W]) && (out_data[FRAC_W-1:0] == '0));

  // R8
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(&out_data[W-2 -: EXP_W]) |-> out_data[FRAC_W-8:0] == '0);

  // R7
  positive_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_divzero |-> !out_data[W-1]);

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_divzero));

endmodule

bind rsq_est rsq_est_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/rsq_est_tb.sv
`timescale 1ns/100ps
module rsq_est_tb_top;

  localparam int E = 8;
  localparam int S = 23;
  localparam int W = 1 + E + S;
  localparam int B = (1 << (E - 1)) - 1;
  localparam logic [W-1:0] CNAN = 32'h7FC00000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic         out_invalid;
  logic         out_divzero;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rsq_est #(.EXP_W(E), .FRAC_W(S)) dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .out_invalid, .out_divzero
  );

  // expected {invalid, divzero, word}, built from the requirement text with real arithmetic
  function automatic logic [W+1:0] model(input logic [W-1:0] x);
    logic          s;
    int            e;
    int            z;
    int            ne;
    int            idx;
    int            k;
    int            oe;
    logic [S-1:0]  f;
    logic [S-1:0]  nf;
    real           m;
    real           v;
    s = x[W-1];
    e = int'(x[W-2 -: E]);
    f = x[S-1:0];
    if (e == (1 << E) - 1) begin
      if (f == '0) return s ? {2'b10, CNAN} : {2'b00, {W{1'b0}}};
      return f[S-1] ? {2'b00, CNAN} : {2'b10, CNAN};
    end
    if (e == 0 && f == '0) return {2'b01, s, {E{1'b1}}, {S{1'b0}}};
    if (s) return {2'b10, CNAN};
    ne = e;
    nf = f;
    if (e == 0) begin
      z = 0;
      while (z < S && !f[S-1-z]) z++;
      ne = -z;
      nf = S'(f << (z + 1));
    end
    idx = int'(nf[S-1 -: 6]);
    m = 1.0 + (2.0 * idx + 1.0) / 128.0;
    v = ((ne & 1) != 0) ? 2.0 / $sqrt(m) : $sqrt(2.0) / $sqrt(m);
    k = $rtoi(v * 128.0 + 0.5) - 128;
    if (k > 127) k = 127;
    oe = (3 * B - 1 - ne) / 2;
    return {2'b00, 1'b0, E'(oe), 7'(k), {(S-7){1'b0}}};
  endfunction

  function automatic string req_of(input logic [W-1:0] x);
    logic [E-1:0] e;
    e = x[W-2 -: E];
    if (&e) return (x[S-1:0] == '0) ? (x[W-1] ? "R3" : "R6") : (x[S-1] ? "R4" : "R3");
    if (e == '0 && x[S-1:0] == '0) return "R5";
    if (x[W-1]) return "R3";
    if (e == '0) return "R9";
    return "R7/R8";
  endfunction

  task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one operand with the consumer always ready; result checked one cycle later
  task automatic run_one(input logic [W-1:0] x, input logic [W-1:0] lit, input bit use_lit,
                         input logic [1:0] lit_flags);
    @(negedge clk);
    in_data  = x;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", {1'b0, out_valid}, {1'b0, 1'b1});
    if (use_lit) chk(req_of(x), {out_invalid, out_divzero, out_data}, {lit_flags, lit});
    else         chk(req_of(x), {out_invalid, out_divzero, out_data}, model(x));
  endtask

  function automatic logic [W-1:0] rand_operand();
    logic [S-1:0] f;
    logic [E-1:0] e;
    int sel;
    sel = int'($urandom() % 8);
    f = S'($urandom());
    e = E'($urandom());
    case (sel)
      0: return W'($urandom());
      1: begin
        f = S'(f >> ($urandom() % S));
        if (f == '0) f = 1;
        return {1'b0, {E{1'b0}}, f};
      end
      2: return {1'b1, e, f};
      3: return {1'(($urandom() % 2)), {E{1'b1}}, f};
      default: begin
        if (e == '0 || &e) e = E'(1 + ($urandom() % ((1 << E) - 2)));
        return {1'b0, e, f};
      end
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {out_valid, in_ready}, {1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {out_valid, in_ready}, {1'b0, 1'b1});

    // R7/R8 directed values
    run_one(32'h3F800000, 32'h3F7F0000, 1'b1, 2'b00);  // 1.0, odd parity
    run_one(32'h40000000, 32'h3F340000, 1'b1, 2'b00);  // 2.0, even parity
    run_one(32'h40800000, 32'h3EFF0000, 1'b1, 2'b00);  // 4.0
    // R9 subnormals at both ends of the leading-zero range
    run_one(32'h00000001, 32'h64B40000, 1'b1, 2'b00);
    run_one(32'h00400000, 32'h5F340000, 1'b1, 2'b00);
    run_one(32'h00200000, 32'h5F7F0000, 1'b1, 2'b00);
    // R5, R6
    run_one(32'h00000000, 32'h7F800000, 1'b1, 2'b01);
    run_one(32'h80000000, 32'hFF800000, 1'b1, 2'b01);
    run_one(32'h7F800000, 32'h00000000, 1'b1, 2'b00);
    // R3
    run_one(32'hFF800000, CNAN, 1'b1, 2'b10);
    run_one(32'hBF800000, CNAN, 1'b1, 2'b10);
    run_one(32'h80000005, CNAN, 1'b1, 2'b10);
    run_one(32'h7F800001, CNAN, 1'b1, 2'b10);
    // R4
    run_one(32'hFFC00001, CNAN, 1'b1, 2'b00);
    run_one(32'h7FC00000, CNAN, 1'b1, 2'b00);

    // R1, R2: back-pressure with a second operand waiting
    @(negedge clk);
    out_ready = 1'b0;
    in_data   = 32'h3F800000;
    in_valid  = 1'b1;
    @(negedge clk);
    chk("R1", {1'b0, out_valid}, {1'b0, 1'b1});
    chk("R2", {1'b0, in_ready}, {1'b0, 1'b0});
    in_data = 32'h00000000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R2", {out_invalid, out_divzero, out_data}, {2'b00, 32'h3F7F0000});
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", {out_invalid, out_divzero, out_data}, {2'b01, 32'h7F800000});
    @(negedge clk);
    chk("R1", {1'b0, out_valid}, {1'b0, 1'b0});

    // random operands against the bench model
    for (int i = 0; i < 3000; i++) run_one(rand_operand(), '0, 1'b0, 2'b00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule